// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K bytes. The host places one request at a time (address, write data, direction) on a valid/ready handshake. The controller then drives the memory's address lines, two chip selects of opposite polarity, output enable, write enable and the data bus so that every cycle-time, pulse-width, setup and hold limit of the memory holds. When the access is complete, it pulses a one-cycle completion strobe, with the read byte for reads.

Every timing limit is a parameter in nanoseconds. Each limit becomes a whole number of clock cycles, rounded up, from a clock-period parameter. A write is framed by write enable alone: both chip selects stay active until write enable has risen and the data has been held for one more cycle. After each access, the memory stays deselected and the bus stays undriven for a turnaround window that covers the memory's bus-release time. The bus is therefore never driven from both sides.

Top module: `asram_ctrl`

## Requirements
- R1: While `req_ready` is high the controller is idle: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_t`=0. This is also the state after reset.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after acceptance and stays low until the access and its turnaround end. A `req_valid` pulse while busy has no effect.
- R3: `mem_we_n` is low only while the memory is selected (`mem_ce1_n`=0, `mem_ce2`=1) and `mem_oe_n` is high.
- R4: Write enable stays low for N_PWE = max(ceil(T_PWE/P), ceil(T_SD/P), ceil(T_AW/P)-1, 1) cycles. One selected cycle with address and data valid comes before it. With the defaults (P=4 ns) N_PWE is 3.
- R5: A write ends by write enable rising while both chip selects are still active and the data is still driven for that cycle. The selected span of a write lasts at least ceil(T_WC/P) cycles.
- R6: A read holds the chip selects active and `mem_oe_n` low for N_RD = max(ceil(T_AA/P), ceil(T_OE/P)) cycles. The byte on `mem_dq_i` at the last edge is returned on `rsp_rdata`, and it equals the last byte written to that address.
- R7: The controller never drives `mem_dq_t`=1 while `mem_oe_n` is low. After an access, at least N_TA = max(ceil(T_HZ/P),1) deselected, undriven cycles follow before the next selection. Output enable falls only after a cycle with the bus undriven.
- R8: `rsp_valid` is high for exactly one cycle per request. It rises N_RD edges after the accepting edge for a read and 2+N_PWE+N_REC edges after it for a write, where N_REC = max(ceil(T_WC/P)-N_PWE-2, 0). Both latencies are 5 with the defaults.
- R9: `mem_addr` does not change while the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read byte, valid with `rsp_valid` after a read |
| mem_addr | output | 17 | Memory address lines |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_t | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Data read from the memory bus |

## Verification
Two functions can meet in a single cycle. The end of one access and the release of the bus can coincide with the start of the next access, where the controller wants to drive data again or open the output enable. The bench issues back-to-back writes and reads to the same and to random addresses and hammers `req_valid` as soon as ready returns. It tracks, cycle by cycle, how long output enable has been high before the controller drives the bus. Each of these is judged against limits computed from the nanosecond parameters: data returned, write-enable pulse length, selected-span length and the bus-release gap. A request pulsed while the controller is busy is checked by reading back the untouched address.

// File: rtl/asram_pkg.sv
// Shared types and helpers for the asynchronous SRAM controller.
// Assumes: callers pass positive clock periods.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_WREC   = 3'd4,
        ST_RACC   = 3'd5,
        ST_TURN   = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic dq_t;
    } mem_pins_t;

    // Nanoseconds to cycles, rounded up.
    function automatic int ns2cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Memory pin levels that belong to each sequencer state.
    function automatic mem_pins_t pins_of(input seq_state_t s);
        mem_pins_t p;
        p = '{ce1_n: 1'b1, ce2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_t: 1'b0};
        case (s)
            ST_WSETUP: begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.dq_t = 1'b1; end
            ST_WPULSE: begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.dq_t = 1'b1; p.we_n = 1'b0; end
            ST_WHOLD:  begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.dq_t = 1'b1; end
            ST_WREC:   begin p.ce1_n = 1'b0; p.ce2 = 1'b1; end
            ST_RACC:   begin p.ce1_n = 1'b0; p.ce2 = 1'b1; p.oe_n = 1'b0; end
            default:   ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Down counter that times the length of a sequencer state.
// Assumes: load is given on entry to a state with the length minus one.
module asram_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Load on state entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_data.sv
// Holds the accepted address and write byte, and captures the read byte.
// Assumes: accept and capture come from the sequencer and are never both high.
module asram_data #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q
);
    // Latch request fields only when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the memory bus at the end of the read access window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= dq_i;
    end
endmodule

// File: rtl/asram_seq.sv
// State sequencer: orders the memory control pins for reads and writes,
// registers the pins glitch-free and flags completion.
// Assumes: all cycle counts are at least one.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CW    = 4,
    parameter int N_PWE = 3,
    parameter int N_REC = 0,
    parameter int N_RD  = 5,
    parameter int N_TA  = 3,
    parameter int N_WC  = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_we,
    input  logic      tmr_zero,
    output logic      idle,
    output logic      accept,
    output logic      capture,
    output logic      tmr_load,
    output logic [CW-1:0] tmr_val,
    output mem_pins_t pins_q,
    output logic      done_q
);
    localparam logic [CW-1:0] L_PWE = CW'(N_PWE - 1);
    localparam logic [CW-1:0] L_REC = CW'((N_REC > 0) ? N_REC - 1 : 0);
    localparam logic [CW-1:0] L_RD  = CW'(N_RD - 1);
    localparam logic [CW-1:0] L_TA  = CW'(N_TA - 1);

    seq_state_t state_q, nxt;
    logic       done_c;

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle && req_valid;

    // Next-state, timer load and completion decisions.
    always_comb begin
        nxt      = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        done_c   = 1'b0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                if (req_we) nxt = ST_WSETUP;
                else begin nxt = ST_RACC; tmr_load = 1'b1; tmr_val = L_RD; end
            end
            ST_WSETUP: begin nxt = ST_WPULSE; tmr_load = 1'b1; tmr_val = L_PWE; end
            ST_WPULSE: if (tmr_zero) nxt = ST_WHOLD;
            ST_WHOLD: begin
                tmr_load = 1'b1;
                if (N_REC > 0) begin nxt = ST_WREC; tmr_val = L_REC; end
                else begin nxt = ST_TURN; tmr_val = L_TA; done_c = 1'b1; end
            end
            ST_WREC: if (tmr_zero) begin
                nxt = ST_TURN; tmr_load = 1'b1; tmr_val = L_TA; done_c = 1'b1;
            end
            ST_RACC: if (tmr_zero) begin
                nxt = ST_TURN; tmr_load = 1'b1; tmr_val = L_TA;
                capture = 1'b1; done_c = 1'b1;
            end
            ST_TURN: if (tmr_zero) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State, registered pin levels and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pins_q  <= pins_of(ST_IDLE);
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            pins_q  <= pins_of(nxt);
            done_q  <= done_c;
        end
    end

    // Checker counters: write-enable low run, selected span, write seen in span.
    logic [7:0] we_run_q, span_q;
    logic       wr_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q  <= '0;
            span_q    <= '0;
            wr_seen_q <= 1'b0;
        end else begin
            we_run_q  <= pins_q.we_n ? 8'd0 : ((we_run_q == 8'hFF) ? we_run_q : we_run_q + 1'b1);
            span_q    <= pins_q.ce1_n ? 8'd0 : ((span_q == 8'hFF) ? span_q : span_q + 1'b1);
            wr_seen_q <= pins_q.ce1_n ? 1'b0 : (wr_seen_q | ~pins_q.we_n);
        end
    end

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_q.we_n) |-> (we_run_q >= 8'(N_PWE)));

    p_write_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pins_q.ce1_n) && wr_seen_q) |-> (span_q >= 8'(N_WC)));

    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !idle);
endmodule

// File: rtl/asram_ctrl.sv
// Top of the asynchronous SRAM controller: host handshake on one side,
// memory pins (split data bus with drive enable) on the other.
// Assumes: one request outstanding at a time; timing limits in ns.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int CLK_NS    = 4,
    parameter int T_WC_NS   = 20,
    parameter int T_PWE_NS  = 12,
    parameter int T_AW_NS   = 15,
    parameter int T_SD_NS   = 10,
    parameter int T_AA_NS   = 20,
    parameter int T_OE_NS   = 9,
    parameter int T_HZ_NS   = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce1_n,
    output logic          mem_ce2,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_t,
    input  logic [DW-1:0] mem_dq_i
);
    localparam int C_AW  = ns2cyc(T_AW_NS, CLK_NS);
    localparam int N_PWE = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                imax((C_AW > 1) ? C_AW - 1 : 1, 1));
    localparam int N_WC  = ns2cyc(T_WC_NS, CLK_NS);
    localparam int N_REC = (N_WC > N_PWE + 2) ? N_WC - N_PWE - 2 : 0;
    localparam int N_RD  = imax(imax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)), 1);
    localparam int N_TA  = imax(ns2cyc(T_HZ_NS, CLK_NS), 1);
    localparam int CW    = $clog2(imax(imax(N_PWE, N_REC), imax(N_RD, N_TA)) + 1) + 1;

    logic          accept, capture, tmr_load, tmr_zero, idle;
    logic [CW-1:0] tmr_val;
    mem_pins_t     pins;

    asram_seq #(
        .CW(CW), .N_PWE(N_PWE), .N_REC(N_REC), .N_RD(N_RD), .N_TA(N_TA), .N_WC(N_WC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .tmr_zero(tmr_zero), .idle(idle), .accept(accept), .capture(capture),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .pins_q(pins), .done_q(rsp_valid)
    );

    asram_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    asram_data #(.AW(AW), .DW(DW)) u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture(capture), .dq_i(mem_dq_i),
        .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rsp_rdata)
    );

    assign req_ready = idle;
    assign mem_ce1_n = pins.ce1_n;
    assign mem_ce2   = pins.ce2;
    assign mem_we_n  = pins.we_n;
    assign mem_oe_n  = pins.oe_n;
    assign mem_dq_t  = pins.dq_t;

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_t));

    p_we_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_oe_n));

    p_end_by_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_t));

    p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_t);

    p_oe_after_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> ($past(!mem_dq_t) && $past(mem_ce1_n)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
endmodule

// File: tb/asram_ctrl_tb.sv
// Self-checking bench: behavioural memory model, timing monitors,
// directed corners and seeded random traffic.
module asram_ctrl_tb;
    localparam int PER = 4;
    // Expected cycle counts derived from the ns limits (ceil).
    localparam int E_PWE = 3;  // max(12/4, 10/4, 15/4-1) rounded up
    localparam int E_WC  = 5;  // 20/4
    localparam int E_TA  = 3;  // 10/4 rounded up
    localparam int E_AWC = 4;  // 15/4 rounded up
    localparam int RD_LAT = 5;
    localparam int WR_LAT = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_t;
    logic [7:0]  rsp_rdata, mem_dq_o, mem_dq_i;
    logic [16:0] mem_addr;

    int checks = 0, errors = 0, cyc = 0;

    always #(PER/2) clk = ~clk;

    asram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_t(mem_dq_t),
        .mem_dq_i(mem_dq_i)
    );

    // Memory model and the bench's reference contents.
    logic [7:0] model_mem [int];
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] model_rd(input logic [16:0] a);
        return model_mem.exists(int'(a)) ? model_mem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [7:0] ref_rd(input logic [16:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    always_comb begin
        if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) mem_dq_i = model_rd(mem_addr);
        else mem_dq_i = 8'h00;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Pin monitor at the falling edge: timing limits and memory writes.
    int          we_low = 0, sel_cnt = 0, oe_hi = 100;
    bit          span_wr = 0, mon_on = 0;
    logic [16:0] pend_a;
    logic [7:0]  pend_d;
    logic        we_prev = 1'b1, ce_prev = 1'b1;
    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_dq_t) chk(oe_hi >= E_TA, "R7 bus driven too soon after oe release", oe_hi, E_TA);
            if (req_ready) chk(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_t,
                               "R1 idle pins", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_t}, 5'b10110);
            if (!mem_we_n) begin
                chk(!mem_ce1_n && mem_ce2 && mem_oe_n, "R3 we low without select", {mem_ce1_n, mem_ce2, mem_oe_n}, 3'b011);
                pend_a = mem_addr; pend_d = mem_dq_o;
            end
            if (mem_we_n && !we_prev) begin
                chk(we_low >= E_PWE, "R4 write pulse cycles", we_low, E_PWE);
                chk(sel_cnt >= E_AWC, "R4 address valid to write end", sel_cnt, E_AWC);
                chk(!mem_ce1_n && mem_ce2 && mem_dq_t && mem_dq_o == pend_d,
                    "R5 write end by we with data held", {mem_ce1_n, mem_ce2, mem_dq_t}, 3'b011);
                model_mem[int'(pend_a)] = pend_d;
            end
            if (mem_ce1_n && !ce_prev && span_wr)
                chk(sel_cnt >= E_WC, "R5 write cycle span", sel_cnt, E_WC);
        end
        we_low  = mem_we_n ? 0 : we_low + 1;
        span_wr = mem_ce1_n ? 1'b0 : (span_wr | ~mem_we_n);
        sel_cnt = mem_ce1_n ? 0 : sel_cnt + 1;
        oe_hi   = !mem_oe_n ? 0 : ((oe_hi < 100) ? oe_hi + 1 : oe_hi);
        we_prev = mem_we_n;
        ce_prev = mem_ce1_n;
    end

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One request; optional poke of a conflicting request while busy.
    task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d,
                         input bit poke, input logic [16:0] pa);
        int n;
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 ready low after accept", req_ready, 0);
        if (we) ref_mem[int'(a)] = d;
        n = 1;
        while (!rsp_valid && n < 100) begin
            if (poke && n == 2) begin
                req_valid = 1'b1; req_we = 1'b1; req_addr = pa; req_wdata = 8'h99;
            end else if (poke && n == 3) begin
                req_valid = 1'b0;
            end
            @(negedge clk); n++;
        end
        req_valid = 1'b0;
        chk(n == (we ? WR_LAT : RD_LAT) + 1, "R8 completion latency", n, (we ? WR_LAT : RD_LAT) + 1);
        if (!we) chk(rsp_rdata == ref_rd(a), "R6 read data", rsp_rdata, ref_rd(a));
        @(negedge clk);
        chk(!rsp_valid, "R8 completion is one cycle", rsp_valid, 0);
    endtask

    initial begin
        logic [16:0] pool [16];
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7);
        for (int i = 0; i < 16; i++) pool[i] = 17'($urandom);
        pool[0] = 17'h00000; pool[1] = 17'h1FFFF;

        repeat (4) @(negedge clk);
        chk(req_ready && mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_t && !rsp_valid,
            "R1 reset state", {req_ready, mem_ce1_n, mem_ce2, mem_dq_t}, 4'b1100);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        // Directed corners: extreme addresses and data, write then read back.
        do_op(1'b1, 17'h00000, 8'hFF, 1'b0, '0);
        do_op(1'b1, 17'h1FFFF, 8'h00, 1'b0, '0);
        do_op(1'b0, 17'h00000, 8'h00, 1'b0, '0);
        do_op(1'b0, 17'h1FFFF, 8'h00, 1'b0, '0);
        do_op(1'b1, 17'h1FFFF, 8'hA5, 1'b0, '0);
        do_op(1'b0, 17'h1FFFF, 8'h00, 1'b0, '0);
        // R2: a request pulsed while busy must not write address 0x00123.
        do_op(1'b1, 17'h00123, 8'h11, 1'b0, '0);
        do_op(1'b1, 17'h00456, 8'h22, 1'b1, 17'h00123);
        do_op(1'b0, 17'h00123, 8'h00, 1'b1, 17'h00123);
        do_op(1'b0, 17'h00123, 8'h00, 1'b0, '0);
        // R9 check during a read: address held while selected.
        // Random mix (R6, R7, R8 under back-to-back traffic).
        for (int k = 0; k < 400; k++) begin
            logic [16:0] a;
            a = ($urandom % 4 == 0) ? 17'($urandom) : pool[$urandom % 16];
            do_op(1'($urandom % 2), a, 8'($urandom), 1'b0, '0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // R9: address must not move while the memory stays selected.
    logic [16:0] addr_prev;
    logic        sel_prev = 1'b0;
    always @(negedge clk) begin
        if (mon_on && sel_prev && !mem_ce1_n)
            chk(mem_addr == addr_prev, "R9 address stable while selected", mem_addr, addr_prev);
        addr_prev = mem_addr;
        sel_prev  = !mem_ce1_n;
    end
endmodule